// File: doc/BRIEF.md
# Pipelined Program Sequencer with Delayed Branch

This block is the fetch-side control of a four-stage instruction pipeline: fetch, decode, operand read and execute. It holds the program counter, presents it to an instruction memory read port, and carries each fetched word with its address through three stage registers. The word in the execute stage is driven out for the datapath. While one instruction executes, the next three sit in read, decode and fetch.

Later stages send decoded requests back while the requesting instruction sits in execute.
- A standard branch discards the three younger instructions.
- A delayed branch lets them complete.
- A count-down loop instruction decrements one of a set of auxiliary counters and branches, with delay, while the result is nonzero.
- A block-repeat request loads a start address, an end address and a count. Fetch then wraps back from the end address with no extra cycles.

A stall input from memory-conflict logic freezes everything. The instruction memory port returns its word in the same cycle as the address. There is no valid/ready handshake on it: back-pressure is carried only by the stall pin, and the sequencer holds its address and all stage contents for as long as the stall is high.

Top module: `prog_sequencer`

## Requirements
- R1: While reset is asserted, `imem_addr` equals the parameter RESET_VEC and `ex_valid` is 0. After release, the word fetched from RESET_VEC reaches execute at the third rising edge.
- R2: With no request taken, `imem_addr` steps up by one on each non-stalled edge. Each fetched word and its address appear on `ex_instr` and `ex_pc` exactly three non-stalled edges after being fetched.
- R3: A taken non-delayed branch (`br_req`=1, `br_cond`=1, `br_delayed`=0 while `ex_valid`=1) discards the three younger instructions. `ex_valid` reads 0 for the next three cycles, and the target appears in execute on the fourth edge after the branch executed.
- R4: A taken delayed branch (`br_delayed`=1) lets the three instructions that follow it execute in order without bubbles. The target executes on the fourth edge.
- R5: A branch request with `br_cond`=0 changes nothing: sequential fetch continues with no bubble.
- R6: `dbnz_req` decrements auxiliary counter `dbnz_sel`. If the decremented value is nonzero, it acts as a delayed branch to `br_target`; if it is zero, execution falls through. Counters are loaded through `ar_wr_en`/`ar_wr_sel`/`ar_wr_data`.
- R7: `rpt_req` loads start, end and count. When the fetch address equals the end address and the count is nonzero, the next fetch is the start address and the count drops by one. When the count is zero, fetch falls through and repeat ends. The block therefore runs count+1 times. The end address must lie beyond the fetch address at the time of the load.
- R8: While `stall` is 1, `imem_addr`, `ex_valid`, `ex_pc` and `ex_instr` hold, and branch, loop and repeat requests are ignored. After the stall, the pipeline resumes with no instruction lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze all stages |
| imem_addr | output | ADDR_W | Fetch address (program counter) |
| imem_data | input | INSTR_W | Instruction word at imem_addr |
| br_req | input | 1 | Branch decoded in execute |
| br_delayed | input | 1 | Branch keeps its three slots |
| br_cond | input | 1 | Branch condition met |
| br_target | input | ADDR_W | Target for branch and loop |
| dbnz_req | input | 1 | Count-down loop in execute |
| dbnz_sel | input | SEL_W | Counter chosen by the loop |
| ar_wr_en | input | 1 | Counter write strobe |
| ar_wr_sel | input | SEL_W | Counter written |
| ar_wr_data | input | AR_W | Counter write value |
| rpt_req | input | 1 | Block-repeat load in execute |
| rpt_start | input | ADDR_W | First address of the block |
| rpt_end | input | ADDR_W | Last address of the block |
| rpt_count | input | CNT_W | Extra passes through the block |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_pc | output | ADDR_W | Address of the executing word |
| ex_instr | output | INSTR_W | Executing word |

## Verification
The hardest situations to reach from the ports have the fetch address three words ahead of the instruction that issues a request. Examples are a repeat wrap whose end comparison happens at fetch while the load happened at execute, and a stall held over a live branch request. The bench reaches them by stepping until a chosen address shows on `ex_pc`, then raising the request for exactly one edge. It then follows the executed address stream edge by edge through slots, bubbles, wraps and the stall window.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ,
    NPC_BRANCH,
    NPC_LOOP,
    NPC_HOLD
  } npc_sel_e;
endpackage

// File: rtl/seq_pcgen.sv
module seq_pcgen
  import seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target,
  input  logic              rpt_load,
  input  logic [ADDR_W-1:0] rpt_start,
  input  logic [ADDR_W-1:0] rpt_end,
  input  logic [CNT_W-1:0]  rpt_count,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q, rs_q, re_q;
  logic [CNT_W-1:0]  rc_q;
  logic              rpt_on_q;
  logic              at_end;
  npc_sel_e          sel;

  assign at_end = rpt_on_q && (pc_q == re_q);

  always_comb begin
    if (!adv)                          sel = NPC_HOLD;
    else if (redirect)                 sel = NPC_BRANCH;
    else if (at_end && (rc_q != '0))   sel = NPC_LOOP;
    else                               sel = NPC_SEQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_VEC;
    else begin
      unique case (sel)
        NPC_BRANCH: pc_q <= target;
        NPC_LOOP:   pc_q <= rs_q;
        NPC_SEQ:    pc_q <= pc_q + ADDR_W'(1);
        default:    pc_q <= pc_q;
      endcase
    end
  end

  // repeat context: load from execute, count down at fetch-side end match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0; re_q <= '0; rc_q <= '0; rpt_on_q <= 1'b0;
    end else if (adv) begin
      if (rpt_load) begin
        rs_q <= rpt_start; re_q <= rpt_end; rc_q <= rpt_count; rpt_on_q <= 1'b1;
      end else if (at_end && !redirect) begin
        if (rc_q != '0) rc_q <= rc_q - CNT_W'(1);
        else            rpt_on_q <= 1'b0;
      end
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/seq_pipe.sv
module seq_pipe #(
  parameter int ADDR_W = 24,
  parameter int INSTR_W = 32,
  parameter int NSTAGE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               squash,
  input  logic [ADDR_W-1:0]  f_pc,
  input  logic [INSTR_W-1:0] f_instr,
  output logic               ex_valid,
  output logic [ADDR_W-1:0]  ex_pc,
  output logic [INSTR_W-1:0] ex_instr
);
  logic               v_q  [NSTAGE];
  logic [ADDR_W-1:0]  pc_q [NSTAGE];
  logic [INSTR_W-1:0] in_q [NSTAGE];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic               src_v;
    logic [ADDR_W-1:0]  src_pc;
    logic [INSTR_W-1:0] src_in;
    if (s == 0) begin : g_head
      assign src_v = 1'b1;
      assign src_pc = f_pc;
      assign src_in = f_instr;
    end else begin : g_body
      assign src_v = v_q[s-1];
      assign src_pc = pc_q[s-1];
      assign src_in = in_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0; pc_q[s] <= '0; in_q[s] <= '0;
      end else if (adv) begin
        v_q[s]  <= src_v && !squash;
        pc_q[s] <= src_pc;
        in_q[s] <= src_in;
      end
    end
  end

  assign ex_valid = v_q[NSTAGE-1];
  assign ex_pc    = pc_q[NSTAGE-1];
  assign ex_instr = in_q[NSTAGE-1];
endmodule

// File: rtl/seq_auxregs.sv
module seq_auxregs #(
  parameter int NUM_AR = 8,
  parameter int AR_W = 24,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [AR_W-1:0]  wr_data,
  input  logic             dec_en,
  input  logic [SEL_W-1:0] dec_sel,
  output logic             dec_nz
);
  logic [AR_W-1:0] ar_q [NUM_AR];
  logic [AR_W-1:0] dec_val;

  assign dec_val = ar_q[dec_sel] - AR_W'(1);
  assign dec_nz  = (dec_val != '0);

  for (genvar r = 0; r < NUM_AR; r++) begin : g_ar
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ar_q[r] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(r))) ar_q[r] <= wr_data;
      else if (dec_en && (dec_sel == SEL_W'(r))) ar_q[r] <= dec_val;
    end
  end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
  parameter int ADDR_W = 24,
  parameter int INSTR_W = 32,
  parameter int NUM_AR = 8,
  parameter int AR_W = 24,
  parameter int CNT_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 24'h000010,
  localparam int SEL_W = $clog2(NUM_AR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall,
  output logic [ADDR_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic               br_req,
  input  logic               br_delayed,
  input  logic               br_cond,
  input  logic [ADDR_W-1:0]  br_target,
  input  logic               dbnz_req,
  input  logic [SEL_W-1:0]   dbnz_sel,
  input  logic               ar_wr_en,
  input  logic [SEL_W-1:0]   ar_wr_sel,
  input  logic [AR_W-1:0]    ar_wr_data,
  input  logic               rpt_req,
  input  logic [ADDR_W-1:0]  rpt_start,
  input  logic [ADDR_W-1:0]  rpt_end,
  input  logic [CNT_W-1:0]   rpt_count,
  output logic               ex_valid,
  output logic [ADDR_W-1:0]  ex_pc,
  output logic [INSTR_W-1:0] ex_instr
);
  logic adv, ex_live, take_br, take_loop, redirect, squash, loop_nz, rpt_load;

  assign adv       = !stall;
  assign ex_live   = adv && ex_valid;
  assign take_br   = ex_live && br_req && br_cond;
  assign take_loop = ex_live && dbnz_req && loop_nz;
  assign redirect  = take_br || take_loop;
  assign squash    = take_br && !br_delayed;
  assign rpt_load  = ex_live && rpt_req;

  seq_pcgen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_VEC(RESET_VEC)) u_pcgen (
    .clk(clk), .rst_n(rst_n), .adv(adv), .redirect(redirect), .target(br_target),
    .rpt_load(rpt_load), .rpt_start(rpt_start), .rpt_end(rpt_end),
    .rpt_count(rpt_count), .pc_o(imem_addr)
  );

  seq_pipe #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .NSTAGE(3)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv), .squash(squash),
    .f_pc(imem_addr), .f_instr(imem_data),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr)
  );

  seq_auxregs #(.NUM_AR(NUM_AR), .AR_W(AR_W), .SEL_W(SEL_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .wr_en(ar_wr_en), .wr_sel(ar_wr_sel),
    .wr_data(ar_wr_data), .dec_en(ex_live && dbnz_req), .dec_sel(dbnz_sel),
    .dec_nz(loop_nz)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 24,
  parameter int INSTR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stall,
  input logic               br_req,
  input logic               br_delayed,
  input logic               br_cond,
  input logic [ADDR_W-1:0]  br_target,
  input logic [ADDR_W-1:0]  imem_addr,
  input logic               ex_valid,
  input logic [ADDR_W-1:0]  ex_pc,
  input logic [INSTR_W-1:0] ex_instr
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (imem_addr == RESET_VEC) && !ex_valid);

  assert_flush_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ex_valid && br_req && br_cond && !br_delayed) |=> !ex_valid);

  assert_flush_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ex_valid && br_req && br_cond && !br_delayed)
      |=> imem_addr == $past(br_target));

  assert_delay_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ex_valid && br_req && br_cond && br_delayed)
      |=> ex_valid && (imem_addr == $past(br_target)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(imem_addr) && $stable(ex_valid) && $stable(ex_pc) && $stable(ex_instr));
endmodule

bind prog_sequencer seq_checker #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .br_req(br_req), .br_delayed(br_delayed),
  .br_cond(br_cond), .br_target(br_target), .imem_addr(imem_addr),
  .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr)
);

// File: tb/sim_prog_sequencer.sv
module sim_prog_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [23:0] imem_addr;
  logic [31:0] imem_data;
  logic        br_req = 1'b0, br_delayed = 1'b0, br_cond = 1'b0;
  logic [23:0] br_target = '0;
  logic        dbnz_req = 1'b0;
  logic [2:0]  dbnz_sel = '0;
  logic        ar_wr_en = 1'b0;
  logic [2:0]  ar_wr_sel = '0;
  logic [23:0] ar_wr_data = '0;
  logic        rpt_req = 1'b0;
  logic [23:0] rpt_start = '0, rpt_end = '0;
  logic [15:0] rpt_count = '0;
  logic        ex_valid;
  logic [23:0] ex_pc;
  logic [31:0] ex_instr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] word_at(input logic [23:0] a);
    return {8'hC3, a};
  endfunction
  assign imem_data = word_at(imem_addr);

  prog_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .imem_addr(imem_addr), .imem_data(imem_data),
    .br_req(br_req), .br_delayed(br_delayed), .br_cond(br_cond), .br_target(br_target),
    .dbnz_req(dbnz_req), .dbnz_sel(dbnz_sel), .ar_wr_en(ar_wr_en), .ar_wr_sel(ar_wr_sel),
    .ar_wr_data(ar_wr_data), .rpt_req(rpt_req), .rpt_start(rpt_start), .rpt_end(rpt_end),
    .rpt_count(rpt_count), .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check_ex(input logic [23:0] exp, input string tag);
    total++;
    if (!ex_valid || ex_pc !== exp || ex_instr !== word_at(exp)) begin
      bad++;
      $display("FAIL %s: ex_valid=%0b ex_pc=%h ex_instr=%h expected pc=%h instr=%h",
               tag, ex_valid, ex_pc, ex_instr, exp, word_at(exp));
    end
  endtask

  task automatic check_bubble(input string tag);
    total++;
    if (ex_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s: ex_valid=%0b ex_pc=%h expected ex_valid=0", tag, ex_valid, ex_pc);
    end
  endtask

  task automatic check_addr(input logic [23:0] exp, input string tag);
    total++;
    if (imem_addr !== exp) begin
      bad++;
      $display("FAIL %s: imem_addr=%h expected %h", tag, imem_addr, exp);
    end
  endtask

  // checks first, first+1, ... one per edge; returns sampled at the last one
  task automatic expect_run(input logic [23:0] first, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      check_ex(first + 24'(k), tag);
      if (k < n - 1) step();
    end
  endtask

  task automatic wait_ex(input logic [23:0] a, input string tag);
    int guard;
    guard = 0;
    while (!(ex_valid && ex_pc == a) && guard < 64) begin
      step();
      guard++;
    end
    if (guard >= 64) begin
      total++; bad++;
      $display("FAIL %s: ex_pc=%h never reached expected %h", tag, ex_pc, a);
    end
  endtask

  task automatic pulse_branch(input logic dly, input logic cnd, input logic [23:0] t);
    br_req = 1'b1; br_delayed = dly; br_cond = cnd; br_target = t;
    step();
    br_req = 1'b0; br_delayed = 1'b0; br_cond = 1'b0;
  endtask

  task automatic t_reset();
    step(); step();
    check_addr(24'h000010, "R1 reset vector");
    check_bubble("R1 reset bubble");
    rst_n = 1'b1;
  endtask

  task automatic t_sequential();
    step(); step();
    check_bubble("R1 fill bubble");
    step();
    expect_run(24'h000010, 4, "R2 sequential stream");
    check_addr(24'h000016, "R2 fetch runs three ahead");
  endtask

  task automatic t_flush_branch();
    wait_ex(24'h000014, "R3 reach");
    pulse_branch(1'b0, 1'b1, 24'h000100);
    check_bubble("R3 squash 1");
    step(); check_bubble("R3 squash 2");
    step(); check_bubble("R3 squash 3");
    step();
    expect_run(24'h000100, 2, "R3 target after four cycles");
  endtask

  task automatic t_delayed_branch();
    wait_ex(24'h000104, "R4 reach");
    pulse_branch(1'b1, 1'b1, 24'h000200);
    expect_run(24'h000105, 3, "R4 delay slots");
    step();
    expect_run(24'h000200, 2, "R4 target");
  endtask

  task automatic t_cond_false();
    wait_ex(24'h000204, "R5 reach");
    pulse_branch(1'b0, 1'b0, 24'h000300);
    expect_run(24'h000205, 4, "R5 untaken branch");
  endtask

  task automatic t_loop();
    ar_wr_en = 1'b1; ar_wr_sel = 3'd3; ar_wr_data = 24'd2;
    step();
    ar_wr_en = 1'b0;
    wait_ex(24'h000210, "R6 reach");
    dbnz_req = 1'b1; dbnz_sel = 3'd3; br_target = 24'h00020C;
    step();
    dbnz_req = 1'b0;
    expect_run(24'h000211, 3, "R6 loop slots");
    step();
    expect_run(24'h00020C, 5, "R6 loop taken on nonzero");
    dbnz_req = 1'b1;
    step();
    dbnz_req = 1'b0;
    expect_run(24'h000211, 4, "R6 fall through on zero");
  endtask

  task automatic t_repeat(input logic [23:0] a, input logic [23:0] len,
                          input logic [15:0] cnt, input string tag);
    wait_ex(a, tag);
    rpt_req = 1'b1; rpt_start = a + 24'd1; rpt_end = a + len; rpt_count = cnt;
    step();
    rpt_req = 1'b0;
    for (int p = 0; p <= int'(cnt); p++) begin
      expect_run(a + 24'd1, int'(len), tag);
      step();
    end
    expect_run(a + len + 24'd1, 2, tag);
  endtask

  task automatic t_stall();
    wait_ex(24'h000240, "R8 reach");
    stall = 1'b1;
    br_req = 1'b1; br_cond = 1'b1; br_target = 24'h000300;
    for (int k = 0; k < 3; k++) begin
      step();
      check_ex(24'h000240, "R8 execute held");
      check_addr(24'h000243, "R8 fetch held");
    end
    stall = 1'b0; br_req = 1'b0; br_cond = 1'b0;
    step();
    expect_run(24'h000241, 4, "R8 resume without loss, request ignored");
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_flush_branch();
    t_delayed_branch();
    t_cond_false();
    t_loop();
    t_repeat(24'h000220, 24'd5, 16'd2, "R7 repeat three passes");
    t_repeat(24'h000230, 24'd4, 16'd0, "R7 repeat count zero");
    t_stall();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule